// File: doc/BRIEF.md
# Four-Channel Shadowed Pulse-Width Modulator

This block drives four pulse-width modulated outputs, one pin per channel. A small synchronous read/write bus programs it. Each channel counts cycles of the peripheral clock. Its period is given by a range value and its high time by a duty value. The channel produces a trailing-edge mark/space waveform, which can be inverted.

Software never writes the live configuration directly. Every write lands in a shadow copy. Setting the update bit of the global control word then commits every shadow value at once: the enables, the modes, the polarities, the ranges and the duties. A channel that is already producing pulses takes the committed values at the end of its current period, so no pulse is cut short. A channel that is idle takes them immediately. The update bit clears itself on the next clock.

Top module: `pwm_bank`

## Requirements
- R1: After reset every output is low. The global word reads 0x00000000. Each channel control word reads 0x00000100, which means bit 8 is set and the mode is off. Every range and duty reads 0.
- R2: The global word is at offset 0x00. For channel n, the control word is at 0x14+16n, the range at 0x18+16n and the duty at 0x20+16n.
  - The control word keeps mode in bits [1:0], invert in bit 3 and a mask bit in bit 8. All its other bits read 0.
  - Range and duty keep their low 16 bits.
  - An unmapped offset reads 0.
  - Read data appears on the cycle after the read request.
- R3: Writes change only shadow copies. The outputs keep their current behaviour until a commit.
- R4: Writing the global word with bit 31 set requests a commit. A read issued on the very next cycle returns bit 31 as 1. Any later read returns it as 0. Bits [3:0] of the global word are the channel enables.
- R5: In mode 1 with the channel enabled, the channel counts 0 to range−1 and then wraps. The output is high while the count is below duty and low otherwise.
- R6: A duty of 0 gives a constant low output. A duty of at least range gives a constant high output.
- R7: A disabled channel, or one whose mode is not 1, holds its count at 0 and drives its inactive level. That level is low, or high when bit 3 is set.
- R8: Control bit 3 inverts the channel output in every state.
- R9: A channel that is running when a commit arrives takes the new values at its next wrap. A channel that is idle takes them on the cycle after the commit.
- R10: Control bit 8 has no effect on any output.
- R11: The four channels run independently, each with its own range and duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after the request |
| pwm_out | output | 4 | Modulated outputs, bit n is channel n |

## Verification
A reference model in the bench tracks the shadow, staged and live values and the counters. The model is compared with every output bit on every clock, through a sequence of patterns:
- Shadow writes with no commit tell staging apart from live effect.
- One running channel with a short period shows the basic waveform and its wrap point.
- A mix of zero duty, duty above range and an inverted channel, all running together, separates the saturation cases and checks that the channels stay independent.
- A commit that lands mid-period on a running channel shows whether new values wait for the wrap.
- A non-one mode and a disabled inverted channel expose the idle levels.
- Toggling the mask bit shows that it does not matter.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_MS   = 2'd1,
        MODE_RSV2 = 2'd2,
        MODE_RSV3 = 2'd3
    } mode_e;

    typedef struct packed {
        logic  fifo_mask;
        logic  inv;
        mode_e mode;
    } chctl_t;

    localparam chctl_t CHCTL_RST = '{fifo_mask: 1'b1, inv: 1'b0, mode: MODE_OFF};

    localparam int GCTL_OFS   = 'h00;
    localparam int CH_BASE    = 'h14;
    localparam int CH_STRIDE  = 16;
    localparam int CTL_OFS    = 0;
    localparam int RANGE_OFS  = 4;
    localparam int DUTY_OFS   = 12;

    localparam int BIT_INV    = 3;
    localparam int BIT_MASK   = 8;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_bank_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int CNT_W = 16,
    parameter int AW    = 8,
    parameter int DW    = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            bus_sel,
    input  logic                            bus_wr,
    input  logic [AW-1:0]                   bus_addr,
    input  logic [DW-1:0]                   bus_wdata,
    output logic [DW-1:0]                   bus_rdata,
    output logic [NCH-1:0]                  sh_en,
    output chctl_t [NCH-1:0]                sh_ctl,
    output logic [NCH-1:0][CNT_W-1:0]       sh_range,
    output logic [NCH-1:0][CNT_W-1:0]       sh_duty,
    output logic                            commit
);

    localparam int UPD_BIT = DW - 1;
    localparam int PAD_W   = DW - 1 - NCH;

    typedef struct packed {
        logic [NCH-1:0]            en;
        chctl_t [NCH-1:0]          ctl;
        logic [NCH-1:0][CNT_W-1:0] rng;
        logic [NCH-1:0][CNT_W-1:0] duty;
        logic                      upd;
        logic [DW-1:0]             rdata;
    } regs_t;

    regs_t s_d, s_q;
    logic  wr_en, rd_en, wr_glob;

    function automatic logic [AW-1:0] ch_addr(input int n, input int ofs);
        return AW'(CH_BASE + n * CH_STRIDE + ofs);
    endfunction

    always_comb begin
        s_d      = s_q;
        wr_en    = bus_sel && bus_wr;
        rd_en    = bus_sel && !bus_wr;
        wr_glob  = wr_en && (bus_addr == AW'(GCTL_OFS));
        s_d.upd  = wr_glob && bus_wdata[UPD_BIT];
        s_d.rdata = '0;
        if (wr_glob) begin
            s_d.en = bus_wdata[NCH-1:0];
        end
        if (rd_en && (bus_addr == AW'(GCTL_OFS))) begin
            s_d.rdata = {s_q.upd, {PAD_W{1'b0}}, s_q.en};
        end
        for (int n = 0; n < NCH; n++) begin
            if (wr_en && (bus_addr == ch_addr(n, CTL_OFS))) begin
                s_d.ctl[n].fifo_mask = bus_wdata[BIT_MASK];
                s_d.ctl[n].inv       = bus_wdata[BIT_INV];
                s_d.ctl[n].mode      = mode_e'(bus_wdata[1:0]);
            end
            if (wr_en && (bus_addr == ch_addr(n, RANGE_OFS))) begin
                s_d.rng[n] = bus_wdata[CNT_W-1:0];
            end
            if (wr_en && (bus_addr == ch_addr(n, DUTY_OFS))) begin
                s_d.duty[n] = bus_wdata[CNT_W-1:0];
            end
            if (rd_en && (bus_addr == ch_addr(n, CTL_OFS))) begin
                s_d.rdata[BIT_MASK] = s_q.ctl[n].fifo_mask;
                s_d.rdata[BIT_INV]  = s_q.ctl[n].inv;
                s_d.rdata[1:0]      = s_q.ctl[n].mode;
            end
            if (rd_en && (bus_addr == ch_addr(n, RANGE_OFS))) begin
                s_d.rdata = DW'(s_q.rng[n]);
            end
            if (rd_en && (bus_addr == ch_addr(n, DUTY_OFS))) begin
                s_d.rdata = DW'(s_q.duty[n]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
            for (int n = 0; n < NCH; n++) begin
                s_q.ctl[n] <= CHCTL_RST;
            end
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_rdata = s_q.rdata;
    assign sh_en     = s_q.en;
    assign sh_ctl    = s_q.ctl;
    assign sh_range  = s_q.rng;
    assign sh_duty   = s_q.duty;
    assign commit    = s_q.upd;

    logic unused_wdata;
    assign unused_wdata = ^bus_wdata[DW-2:CNT_W];

    // R4: the update request lasts one cycle unless it is written again
    p_update_selfclear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !(wr_glob && bus_wdata[UPD_BIT])) |=> !commit);

    // R3: with no write, the shadow copies keep their values
    p_shadow_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr) |=> ($stable(sh_en) && $stable(sh_ctl)
                                  && $stable(sh_range) && $stable(sh_duty)));

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_bank_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic             sh_en,
    input  chctl_t           sh_ctl,
    input  logic [CNT_W-1:0] sh_range,
    input  logic [CNT_W-1:0] sh_duty,
    output logic             pwm_o
);

    typedef struct packed {
        logic             en;
        chctl_t           ctl;
        logic [CNT_W-1:0] rng;
        logic [CNT_W-1:0] duty;
    } cfg_t;

    typedef struct packed {
        cfg_t             stg;
        cfg_t             act;
        logic             pend;
        logic [CNT_W-1:0] cnt;
    } ch_t;

    ch_t c_d, c_q;
    logic run, wrap, load;
    logic [CNT_W:0] cnt_inc;

    assign run     = c_q.act.en && (c_q.act.ctl.mode == MODE_MS);
    assign cnt_inc = {1'b0, c_q.cnt} + (CNT_W+1)'(1);
    assign wrap    = cnt_inc >= {1'b0, c_q.act.rng};
    assign load    = c_q.pend && (!run || wrap);

    always_comb begin
        c_d = c_q;
        if (!run || wrap) begin
            c_d.cnt = '0;
        end else begin
            c_d.cnt = cnt_inc[CNT_W-1:0];
        end
        if (load) begin
            c_d.act  = c_q.stg;
            c_d.pend = 1'b0;
        end
        if (commit) begin
            c_d.stg.en   = sh_en;
            c_d.stg.ctl  = sh_ctl;
            c_d.stg.rng  = sh_range;
            c_d.stg.duty = sh_duty;
            c_d.pend     = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q         <= '0;
            c_q.stg.ctl <= CHCTL_RST;
            c_q.act.ctl <= CHCTL_RST;
        end else begin
            c_q <= c_d;
        end
    end

    assign pwm_o = (run && (c_q.cnt < c_q.act.duty)) ^ c_q.act.ctl.inv;

    logic unused_mask;
    assign unused_mask = c_q.act.ctl.fifo_mask;

    // R7: an idle channel keeps its counter at zero
    p_idle_cnt_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (c_q.cnt == '0));

    // R5: a running counter never reaches the range value
    p_cnt_below_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (c_q.act.rng != '0)) |-> (c_q.cnt < c_q.act.rng));

    // R9: live values stay put in the middle of a period
    p_hold_mid_period_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wrap) |=> $stable(c_q.act));

    // R9: an idle channel takes a pending commit on the next cycle
    p_idle_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.pend && !run && !commit) |=> !c_q.pend);

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int CNT_W = 16,
    parameter int AW    = 8,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic [NCH-1:0] pwm_out
);

    logic [NCH-1:0]            sh_en;
    chctl_t [NCH-1:0]          sh_ctl;
    logic [NCH-1:0][CNT_W-1:0] sh_range;
    logic [NCH-1:0][CNT_W-1:0] sh_duty;
    logic                      commit;

    pwm_regs #(
        .NCH   (NCH),
        .CNT_W (CNT_W),
        .AW    (AW),
        .DW    (DW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sh_en     (sh_en),
        .sh_ctl    (sh_ctl),
        .sh_range  (sh_range),
        .sh_duty   (sh_duty),
        .commit    (commit)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm_chan #(
            .CNT_W (CNT_W)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .commit   (commit),
            .sh_en    (sh_en[g]),
            .sh_ctl   (sh_ctl[g]),
            .sh_range (sh_range[g]),
            .sh_duty  (sh_duty[g]),
            .pwm_o    (pwm_out[g])
        );
    end

endmodule

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 4;
    localparam int WDOG       = 50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit cmp_on   = 1'b0;
    bit finished = 1'b0;
    string cur_req = "R1";
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_bank u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    // reference model state
    int m_sh_en[NCH], m_sh_mode[NCH], m_sh_inv[NCH], m_sh_rng[NCH], m_sh_duty[NCH];
    int m_st_en[NCH], m_st_mode[NCH], m_st_inv[NCH], m_st_rng[NCH], m_st_duty[NCH];
    int m_ac_en[NCH], m_ac_mode[NCH], m_ac_inv[NCH], m_ac_rng[NCH], m_ac_duty[NCH];
    int m_pend[NCH], m_cnt[NCH];
    int m_upd;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                m_sh_en[i] = 0; m_sh_mode[i] = 0; m_sh_inv[i] = 0; m_sh_rng[i] = 0; m_sh_duty[i] = 0;
                m_st_en[i] = 0; m_st_mode[i] = 0; m_st_inv[i] = 0; m_st_rng[i] = 0; m_st_duty[i] = 0;
                m_ac_en[i] = 0; m_ac_mode[i] = 0; m_ac_inv[i] = 0; m_ac_rng[i] = 0; m_ac_duty[i] = 0;
                m_pend[i] = 0; m_cnt[i] = 0;
            end
            m_upd = 0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                bit running, at_end, take;
                running = (m_ac_en[i] != 0) && (m_ac_mode[i] == 1);
                at_end  = (m_cnt[i] + 1) >= m_ac_rng[i];
                take    = (m_pend[i] != 0) && (!running || at_end);
                m_cnt[i] = (running && !at_end) ? m_cnt[i] + 1 : 0;
                if (take) begin
                    m_ac_en[i] = m_st_en[i]; m_ac_mode[i] = m_st_mode[i]; m_ac_inv[i] = m_st_inv[i];
                    m_ac_rng[i] = m_st_rng[i]; m_ac_duty[i] = m_st_duty[i];
                    m_pend[i] = 0;
                end
                if (m_upd != 0) begin
                    m_st_en[i] = m_sh_en[i]; m_st_mode[i] = m_sh_mode[i]; m_st_inv[i] = m_sh_inv[i];
                    m_st_rng[i] = m_sh_rng[i]; m_st_duty[i] = m_sh_duty[i];
                    m_pend[i] = 1;
                end
            end
            m_upd = 0;
            if (bus_sel && bus_wr) begin
                if (bus_addr == 8'h00) begin
                    for (int i = 0; i < NCH; i++) m_sh_en[i] = int'(bus_wdata[i]);
                    m_upd = int'(bus_wdata[31]);
                end
                for (int i = 0; i < NCH; i++) begin
                    if (int'(bus_addr) == 'h14 + 16*i) begin
                        m_sh_mode[i] = int'(bus_wdata[1:0]);
                        m_sh_inv[i]  = int'(bus_wdata[3]);
                    end
                    if (int'(bus_addr) == 'h18 + 16*i) m_sh_rng[i]  = int'(bus_wdata[15:0]);
                    if (int'(bus_addr) == 'h20 + 16*i) m_sh_duty[i] = int'(bus_wdata[15:0]);
                end
            end
        end
    end

    function automatic int model_out();
        int v = 0;
        for (int i = 0; i < NCH; i++) begin
            bit b;
            b = (m_ac_en[i] != 0) && (m_ac_mode[i] == 1) && (m_cnt[i] < m_ac_duty[i]);
            if (m_ac_inv[i] != 0) b = !b;
            if (b) v = v | (1 << i);
        end
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on) begin
            check(int'(pwm_out) == model_out(), cur_req, int'(pwm_out), model_out());
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG) begin
            check(1'b0, "watchdog", cyc, WDOG);
            summary();
        end
    end

    // tasks are entered at a falling edge and return at one
    task automatic bus_write(input int addr, input logic [31:0] data);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'(addr); bus_wdata = data;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input int addr, input logic [31:0] exp, input string req);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'(addr);
        @(negedge clk);
        bus_sel = 1'b0;
        check(bus_rdata == exp, req, int'(bus_rdata), int'(exp));
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_on = 1'b1;

        // R1: reset values
        cur_req = "R1";
        check(pwm_out == 4'b0000, "R1 outputs low", int'(pwm_out), 0);
        bus_read('h00, 32'h0000_0000, "R1 global");
        bus_read('h14, 32'h0000_0100, "R1 ctl ch0");
        bus_read('h48, 32'h0000_0000, "R1 range ch3");
        bus_read('h30, 32'h0000_0000, "R1 duty ch1");

        // R2: map, field masking, unmapped offsets
        cur_req = "R2";
        bus_write('h44, 32'hFFFF_FFFF);
        bus_read('h44, 32'h0000_010B, "R2 ctl ch3 fields");
        bus_write('h38, 32'h1234_ABCD);
        bus_read('h38, 32'h0000_ABCD, "R2 range ch2 width");
        bus_read('h1C, 32'h0000_0000, "R2 unmapped 0x1C");
        bus_read('h04, 32'h0000_0000, "R2 unmapped 0x04");

        // R3: shadow writes without commit
        cur_req = "R3";
        bus_write('h14, 32'h0000_0101);
        bus_write('h18, 32'd5);
        bus_write('h20, 32'd2);
        bus_write('h00, 32'h0000_0001);
        idle(12);
        check(pwm_out == 4'b0000, "R3 no effect before commit", int'(pwm_out), 0);

        // R4: update bit self-clears; R5 waveform after it
        cur_req = "R4";
        bus_write('h00, 32'h8000_0001);
        bus_read('h00, 32'h8000_0001, "R4 update visible next cycle");
        bus_read('h00, 32'h0000_0001, "R4 update cleared");
        cur_req = "R5";
        idle(20);

        // R6, R8, R11: saturation, inversion, independent channels
        cur_req = "R6 R8 R11";
        bus_write('h24, 32'h0000_0001);
        bus_write('h28, 32'd4);
        bus_write('h30, 32'd0);
        bus_write('h34, 32'h0000_0001);
        bus_write('h38, 32'd4);
        bus_write('h40, 32'd7);
        bus_write('h44, 32'h0000_0109);
        bus_write('h48, 32'd3);
        bus_write('h50, 32'd1);
        bus_write('h00, 32'h8000_000F);
        idle(24);

        // R9: mid-period commit on a running channel
        cur_req = "R9";
        bus_write('h18, 32'd8);
        bus_write('h20, 32'd6);
        idle(1);
        bus_write('h00, 32'h8000_000F);
        idle(30);

        // R7: non-one mode and disabled inverted channel
        cur_req = "R7";
        bus_write('h24, 32'h0000_0002);
        bus_write('h00, 32'h8000_0007);
        idle(20);
        check(pwm_out[3] == 1'b1, "R7 disabled inverted is high", int'(pwm_out[3]), 1);
        check(pwm_out[1] == 1'b0, "R7 mode 2 is low", int'(pwm_out[1]), 0);

        // R10: mask bit cleared then set again
        cur_req = "R10";
        bus_write('h14, 32'h0000_0001);
        bus_write('h00, 32'h8000_0007);
        idle(20);
        bus_write('h14, 32'h0000_0101);
        bus_write('h00, 32'h8000_0007);
        idle(20);
        bus_read('h14, 32'h0000_0101, "R10 mask stored");

        cmp_on = 1'b0;
        summary();
    end

endmodule